// File: doc/BRIEF.md
# SPI Receive Byte FIFO with Selectable Fill Threshold

This block holds the receive data of an SPI port. The shift engine hands it each deserialized frame with a one-cycle strobe. The block masks the frame to the configured data size and stores it in a small ring of bytes. A frame of eight bits or fewer takes one byte. A wider frame takes two bytes, with the low byte stored first. Software or a DMA engine drains the ring through a read port that is either one byte or two bytes wide.

A receive-ready flag tells the reader when enough data is waiting. A configuration bit sets the level that raises the flag:
- half the ring, for 16-bit readers;
- a quarter of the ring, for 8-bit readers.

The flag drives a DMA request and an interrupt request, each gated by its own enable. When a frame arrives and there is no room for it, the frame is discarded and a sticky overrun flag is set. The overrun flag drives the error interrupt, which also has its own enable.

When 8-bit frames are read in pairs by DMA, an odd total frame count would leave one byte stranded below the half-full level. A lock-protected odd-count bit covers this case. Together with a programmed frame total, it lowers the threshold to one byte once the final frame has been received.

Top module: `spi_rx_fifo`

## Requirements
- R1: The ring holds DEPTH bytes (default 4), and `level_o` reports its fill level in bytes.
  - A frame size code c (data bits c+1) of 3..15 is used as given. Codes 0..2 act as code 7 (8 bits).
  - Bits of `frame_data_i` above the frame size are stored as zero.
  - A frame of up to 8 bits takes one byte. A wider frame takes two bytes, low byte first.
- R2: With `thr_qtr_i`=0, `rxne_o` is high exactly when the level is at least DEPTH/2 bytes, except under R8.
- R3: With `thr_qtr_i`=1, `rxne_o` is high exactly when the level is at least max(DEPTH/4,1) bytes.
- R4: `rd_data_o` shows the oldest byte in bits [7:0]. Empty positions read as zero.
  - For a wide read (`rd_wide_i`=1) with at least 2 bytes stored, bits [15:8] show the next byte. Otherwise bits [15:8] are zero.
  - A read strobe pops the bytes shown: two for a wide read with at least 2 bytes stored, otherwise one if any byte is stored.
- R5: `dma_req_o` equals `rxne_o` while `dma_en_i`=1, and is 0 otherwise.
- R6: `rxne_irq_o` equals `rxne_o` while `rxne_ie_i`=1, and is 0 otherwise.
- R7: A pulse on `odd_wr_i` loads `odd_val_i` into the odd-count bit, shown on `odd_last_o`, only while `en_i`=0. While `en_i`=1 the pulse is ignored.
- R8: The threshold drops to one byte when all of the following hold:
  - the odd-count bit is 1;
  - `dma_en_i`=1;
  - frames are 8 bits or fewer;
  - `thr_qtr_i`=0;
  - `frame_total_i` is nonzero and equals the number of frames accepted since enable.
- R9: A frame that needs more bytes than are free is discarded and sets `ovr_o`. The free count includes bytes popped by a read in the same cycle.
  - `ovr_o` stays high until a pulse on `ovr_clr_i`.
  - If a new overrun happens in the same cycle as the clear, the overrun wins.
- R10: `err_irq_o` equals `ovr_o` while `err_ie_i`=1, and is 0 otherwise.
- R11: While `en_i`=0 the ring is emptied, the accepted-frame count is cleared, and incoming frames are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Peripheral enable |
| size_i | input | 4 | Frame size code (bits = code+1) |
| thr_qtr_i | input | 1 | 1: quarter threshold, 0: half threshold |
| dma_en_i | input | 1 | Receive DMA enable |
| rxne_ie_i | input | 1 | Receive-ready interrupt enable |
| err_ie_i | input | 1 | Error interrupt enable |
| odd_wr_i | input | 1 | Write strobe for the odd-count bit |
| odd_val_i | input | 1 | Value written to the odd-count bit |
| frame_total_i | input | CNT_W | Programmed number of frames in the transfer |
| frame_vld_i | input | 1 | Frame-in strobe |
| frame_data_i | input | 16 | Received frame, right-aligned |
| rd_i | input | 1 | Read strobe |
| rd_wide_i | input | 1 | 1: 16-bit read, 0: 8-bit read |
| ovr_clr_i | input | 1 | Overrun clear pulse |
| rd_data_o | output | 16 | Read data |
| level_o | output | LW | Fill level in bytes |
| rxne_o | output | 1 | Receive-ready flag |
| dma_req_o | output | 1 | Receive DMA request |
| rxne_irq_o | output | 1 | Receive-ready interrupt |
| err_irq_o | output | 1 | Error interrupt |
| ovr_o | output | 1 | Sticky overrun flag |
| odd_last_o | output | 1 | Odd-count bit |

## Verification
The hardest state to reach is the last-frame threshold drop. It needs several conditions at once: the odd-count bit must have been written while disabled, DMA must be on with 8-bit frames, and the accepted-frame count must equal the programmed total. The bench writes the bit with the block disabled, enables it, and pushes two bytes that a wide read drains. The third byte must then raise the flag alone, which is checked against the one-byte state after the first push.

The same-cycle case of a read and a frame arriving at a full ring is also driven. This shows that the free-space test counts the bytes being popped in that cycle. A disable and re-enable with a total of one then proves that the frame count restarts.

// File: rtl/spi_rx_pkg.sv
package spi_rx_pkg;

  typedef logic [3:0] size_code_t;

  // codes below 3 are reserved and behave as 8-bit
  function automatic logic [4:0] frame_bits(size_code_t c);
    return (c < 4'd3) ? 5'd8 : ({1'b0, c} + 5'd1);
  endfunction

  function automatic logic frame_wide(size_code_t c);
    return frame_bits(c) > 5'd8;
  endfunction

  function automatic logic [15:0] frame_mask(size_code_t c, logic [15:0] d);
    logic [15:0] m;
    for (int i = 0; i < 16; i++) m[i] = d[i] & (i < int'(frame_bits(c)));
    return m;
  endfunction

endpackage

// File: rtl/spi_rx_store.sv
module spi_rx_store #(
  parameter int DEPTH = 4,
  parameter int LW    = $clog2(DEPTH) + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          flush_i,
  input  logic          push_i,
  input  logic          push_two_i,
  input  logic [15:0]   push_data_i,
  input  logic          pop_req_i,
  input  logic          pop_wide_i,
  output logic [LW-1:0] level_o,
  output logic [LW-1:0] pop_cnt_o,
  output logic [7:0]    head0_o,
  output logic [7:0]    head1_o
);
  localparam int AW = $clog2(DEPTH);

  logic [7:0]    mem_q [DEPTH];
  logic [AW-1:0] wr_q, rd_q;
  logic [LW-1:0] lvl_q, push_cnt;

  always_comb begin
    pop_cnt_o = '0;
    if (pop_req_i) begin
      if (pop_wide_i && lvl_q >= LW'(2)) pop_cnt_o = LW'(2);
      else if (lvl_q != '0)              pop_cnt_o = LW'(1);
    end
    push_cnt = !push_i ? '0 : (push_two_i ? LW'(2) : LW'(1));
  end

  always_ff @(posedge clk_i) begin
    if (push_i && !flush_i) begin
      mem_q[wr_q] <= push_data_i[7:0];
      if (push_two_i) mem_q[wr_q + AW'(1)] <= push_data_i[15:8];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      lvl_q <= '0;
    end else if (flush_i) begin
      wr_q  <= '0;
      rd_q  <= '0;
      lvl_q <= '0;
    end else begin
      wr_q  <= wr_q + AW'(push_cnt);
      rd_q  <= rd_q + AW'(pop_cnt_o);
      lvl_q <= lvl_q + push_cnt - pop_cnt_o;
    end
  end

  assign level_o = lvl_q;
  assign head0_o = mem_q[rd_q];
  assign head1_o = mem_q[rd_q + AW'(1)];
endmodule

// File: rtl/spi_rx_flags.sv
module spi_rx_flags #(
  parameter int DEPTH = 4,
  parameter int CNT_W = 8,
  parameter int LW    = $clog2(DEPTH) + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             accept_i,
  input  logic             ovr_set_i,
  input  logic             ovr_clr_i,
  input  logic [LW-1:0]    level_i,
  input  logic             thr_qtr_i,
  input  logic             narrow_i,
  input  logic             dma_en_i,
  input  logic             odd_wr_i,
  input  logic             odd_val_i,
  input  logic [CNT_W-1:0] total_i,
  output logic             rxne_o,
  output logic             ovr_o,
  output logic             odd_o
);
  localparam int HALF = DEPTH / 2;
  localparam int QTR  = (DEPTH / 4 < 1) ? 1 : DEPTH / 4;

  logic [CNT_W-1:0] cnt_q;
  logic             odd_q, ovr_q, final_odd;
  logic [LW-1:0]    need;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      odd_q <= 1'b0;
      ovr_q <= 1'b0;
    end else begin
      if (!en_i)                       cnt_q <= '0;
      else if (accept_i && cnt_q != '1) cnt_q <= cnt_q + CNT_W'(1);
      if (odd_wr_i && !en_i) odd_q <= odd_val_i;
      if (ovr_set_i)       ovr_q <= 1'b1;
      else if (ovr_clr_i)  ovr_q <= 1'b0;
    end
  end

  // lone trailing byte of an odd packed DMA transfer
  assign final_odd = odd_q && dma_en_i && narrow_i && !thr_qtr_i &&
                     (total_i != '0) && (cnt_q == total_i);

  always_comb begin
    if (thr_qtr_i)      need = LW'(QTR);
    else if (final_odd) need = LW'(1);
    else                need = LW'(HALF);
  end

  assign rxne_o = level_i >= need;
  assign ovr_o  = ovr_q;
  assign odd_o  = odd_q;
endmodule

// File: rtl/spi_rx_fifo.sv
module spi_rx_fifo
  import spi_rx_pkg::*;
#(
  parameter  int DEPTH = 4,
  parameter  int CNT_W = 8,
  localparam int LW    = $clog2(DEPTH) + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [3:0]       size_i,
  input  logic             thr_qtr_i,
  input  logic             dma_en_i,
  input  logic             rxne_ie_i,
  input  logic             err_ie_i,
  input  logic             odd_wr_i,
  input  logic             odd_val_i,
  input  logic [CNT_W-1:0] frame_total_i,
  input  logic             frame_vld_i,
  input  logic [15:0]      frame_data_i,
  input  logic             rd_i,
  input  logic             rd_wide_i,
  input  logic             ovr_clr_i,
  output logic [15:0]      rd_data_o,
  output logic [LW-1:0]    level_o,
  output logic             rxne_o,
  output logic             dma_req_o,
  output logic             rxne_irq_o,
  output logic             err_irq_o,
  output logic             ovr_o,
  output logic             odd_last_o
);
  logic          wide, accept, ovr_set;
  logic [LW-1:0] level, pop_cnt, room, need_bytes;
  logic [7:0]    head0, head1;

  assign wide       = frame_wide(size_i);
  assign need_bytes = wide ? LW'(2) : LW'(1);
  assign room       = LW'(DEPTH) - level + pop_cnt;
  assign accept     = frame_vld_i && en_i && (need_bytes <= room);
  assign ovr_set    = frame_vld_i && en_i && !accept;

  spi_rx_store #(.DEPTH(DEPTH), .LW(LW)) u_store (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .flush_i     (!en_i),
    .push_i      (accept),
    .push_two_i  (wide),
    .push_data_i (frame_mask(size_i, frame_data_i)),
    .pop_req_i   (rd_i),
    .pop_wide_i  (rd_wide_i),
    .level_o     (level),
    .pop_cnt_o   (pop_cnt),
    .head0_o     (head0),
    .head1_o     (head1)
  );

  spi_rx_flags #(.DEPTH(DEPTH), .CNT_W(CNT_W), .LW(LW)) u_flags (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (en_i),
    .accept_i  (accept),
    .ovr_set_i (ovr_set),
    .ovr_clr_i (ovr_clr_i),
    .level_i   (level),
    .thr_qtr_i (thr_qtr_i),
    .narrow_i  (!wide),
    .dma_en_i  (dma_en_i),
    .odd_wr_i  (odd_wr_i),
    .odd_val_i (odd_val_i),
    .total_i   (frame_total_i),
    .rxne_o    (rxne_o),
    .ovr_o     (ovr_o),
    .odd_o     (odd_last_o)
  );

  always_comb begin
    rd_data_o = '0;
    if (level != '0) rd_data_o[7:0] = head0;
    if (rd_wide_i && level >= LW'(2)) rd_data_o[15:8] = head1;
  end

  assign level_o    = level;
  assign dma_req_o  = dma_en_i && rxne_o;
  assign rxne_irq_o = rxne_ie_i && rxne_o;
  assign err_irq_o  = err_ie_i && ovr_o;
endmodule

// File: rtl/spi_rx_fifo_chk.sv
module spi_rx_fifo_chk #(
  parameter int DEPTH = 4,
  parameter int LW    = $clog2(DEPTH) + 1
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          en_i,
  input logic          thr_qtr_i,
  input logic          dma_en_i,
  input logic          rxne_ie_i,
  input logic          err_ie_i,
  input logic          ovr_clr_i,
  input logic [LW-1:0] level_o,
  input logic          rxne_o,
  input logic          dma_req_o,
  input logic          rxne_irq_o,
  input logic          err_irq_o,
  input logic          ovr_o,
  input logic          odd_last_o
);
  localparam int HALF = DEPTH / 2;

  AST_LEVEL_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    level_o <= LW'(DEPTH)) else $error("level overflow"); // R1
  AST_HALF_THR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    level_o >= LW'(HALF) |-> rxne_o) else $error("half threshold"); // R2
  AST_QTR_THR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (thr_qtr_i && level_o != '0) |-> rxne_o) else $error("quarter threshold"); // R3
  AST_DMA_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dma_en_i |-> !dma_req_o) else $error("dma ungated"); // R5
  AST_IRQ_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rxne_ie_i |-> !rxne_irq_o) else $error("irq ungated"); // R6
  AST_ODD_LOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |=> $stable(odd_last_o)) else $error("odd bit changed"); // R7
  AST_OVR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovr_o && !ovr_clr_i) |=> ovr_o) else $error("overrun dropped"); // R9
  AST_ERR_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !err_ie_i |-> !err_irq_o) else $error("err ungated"); // R10
  AST_EMPTY_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> level_o == '0) else $error("not flushed"); // R11
endmodule

bind spi_rx_fifo spi_rx_fifo_chk #(.DEPTH(DEPTH)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .en_i       (en_i),
  .thr_qtr_i  (thr_qtr_i),
  .dma_en_i   (dma_en_i),
  .rxne_ie_i  (rxne_ie_i),
  .err_ie_i   (err_ie_i),
  .ovr_clr_i  (ovr_clr_i),
  .level_o    (level_o),
  .rxne_o     (rxne_o),
  .dma_req_o  (dma_req_o),
  .rxne_irq_o (rxne_irq_o),
  .err_irq_o  (err_irq_o),
  .ovr_o      (ovr_o),
  .odd_last_o (odd_last_o)
);

// File: tb/spi_rx_fifo_tb.sv
module spi_rx_fifo_tb;
  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic en_i = 0, thr_qtr_i = 0, dma_en_i = 0, rxne_ie_i = 0, err_ie_i = 0;
  logic odd_wr_i = 0, odd_val_i = 0, frame_vld_i = 0, rd_i = 0, rd_wide_i = 0, ovr_clr_i = 0;
  logic [3:0]  size_i = 4'd7;
  logic [7:0]  frame_total_i = '0;
  logic [15:0] frame_data_i = '0, rd_data_o, d;
  logic [2:0]  level_o;
  logic rxne_o, dma_req_o, rxne_irq_o, err_irq_o, ovr_o, odd_last_o;
  int total = 0, bad = 0;
  bit done = 0;

  always #2.5 clk_i = ~clk_i;

  spi_rx_fifo u_dut (.*);

  typedef struct packed {
    logic [3:0]  sz;
    logic [15:0] din;
    logic        wide;
    logic [15:0] exp;
  } vec_t;

  localparam vec_t VECS [7] = '{
    '{4'd7,  16'hABCD, 1'b0, 16'h00CD},
    '{4'd3,  16'h00FF, 1'b0, 16'h000F},
    '{4'd0,  16'h1234, 1'b0, 16'h0034},
    '{4'd15, 16'hBEEF, 1'b1, 16'hBEEF},
    '{4'd11, 16'hFFFF, 1'b1, 16'h0FFF},
    '{4'd8,  16'h0301, 1'b1, 16'h0101},
    '{4'd4,  16'hFFFF, 1'b0, 16'h001F}
  };

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic push(logic [15:0] v);
    frame_data_i = v; frame_vld_i = 1;
    @(posedge clk_i); #1 frame_vld_i = 0;
    @(negedge clk_i);
  endtask

  task automatic rd(logic w, output logic [15:0] q);
    rd_i = 1; rd_wide_i = w;
    #1 q = rd_data_o;
    @(posedge clk_i); #1 rd_i = 0;
    @(negedge clk_i);
  endtask

  task automatic step();
    @(posedge clk_i); @(negedge clk_i);
  endtask

  initial begin
    repeat (3) @(posedge clk_i);
    @(negedge clk_i) rst_ni = 1;
    chk("R1 reset level", 16'(level_o), 0);
    chk("R2 reset rxne", 16'(rxne_o), 0);
    chk("R9 reset ovr", 16'(ovr_o), 0);
    chk("R7 reset odd", 16'(odd_last_o), 0);

    en_i = 1; thr_qtr_i = 1;
    for (int i = 0; i < 7; i++) begin
      size_i = VECS[i].sz;
      push(VECS[i].din);
      chk("R1 level", 16'(level_o), (VECS[i].sz >= 4'd8) ? 16'd2 : 16'd1);
      rd(VECS[i].wide, d);
      chk("R4 data", d, VECS[i].exp);
      chk("R4 drained", 16'(level_o), 0);
    end

    // R2 half threshold, R5/R6 gating
    size_i = 4'd7; thr_qtr_i = 0;
    push(16'h0011);
    chk("R2 one byte", 16'(rxne_o), 0);
    push(16'h0022);
    chk("R2 two bytes", 16'(rxne_o), 1);
    chk("R5 dma off", 16'(dma_req_o), 0);
    chk("R6 irq off", 16'(rxne_irq_o), 0);
    dma_en_i = 1; rxne_ie_i = 1; #1;
    chk("R5 dma on", 16'(dma_req_o), 1);
    chk("R6 irq on", 16'(rxne_irq_o), 1);
    rd(1, d);
    chk("R4 pair order", d, 16'h2211);
    chk("R5 dma idle", 16'(dma_req_o), 0);
    dma_en_i = 0; rxne_ie_i = 0;

    // R3 quarter threshold
    thr_qtr_i = 1;
    push(16'h0033);
    chk("R3 one byte", 16'(rxne_o), 1);
    rd(0, d);
    chk("R4 narrow", d, 16'h0033);
    push(16'h0044); push(16'h0055);
    rd(0, d);
    chk("R4 narrow of two", d, 16'h0044);
    chk("R4 one popped", 16'(level_o), 1);
    rd(1, d);
    chk("R4 wide of one", d, 16'h0055);
    chk("R4 empty", 16'(level_o), 0);

    // R9/R10 overrun
    size_i = 4'd15; thr_qtr_i = 0;
    push(16'hA1A0); push(16'hB1B0);
    chk("R9 full", 16'(level_o), 4);
    push(16'hC1C0);
    chk("R9 ovr set", 16'(ovr_o), 1);
    chk("R9 discarded", 16'(level_o), 4);
    chk("R10 masked", 16'(err_irq_o), 0);
    err_ie_i = 1; #1;
    chk("R10 enabled", 16'(err_irq_o), 1);
    rd(1, d);
    chk("R9 head kept", d, 16'hA1A0);
    push(16'hC1C0);
    chk("R9 sticky", 16'(ovr_o), 1);
    ovr_clr_i = 1; step(); ovr_clr_i = 0;
    chk("R9 cleared", 16'(ovr_o), 0);
    frame_data_i = 16'hD1D0; frame_vld_i = 1; rd_i = 1; rd_wide_i = 1;
    @(posedge clk_i); #1 frame_vld_i = 0; rd_i = 0;
    @(negedge clk_i);
    chk("R9 same-cycle room", 16'(ovr_o), 0);
    chk("R9 same-cycle level", 16'(level_o), 4);
    rd(1, d);
    chk("R9 order c", d, 16'hC1C0);
    push(16'hE1E0);
    frame_data_i = 16'hF1F0; frame_vld_i = 1; ovr_clr_i = 1;
    @(posedge clk_i); #1 frame_vld_i = 0; ovr_clr_i = 0;
    @(negedge clk_i);
    chk("R9 set wins", 16'(ovr_o), 1);
    rd(1, d);
    chk("R9 order d", d, 16'hD1D0);
    err_ie_i = 0;

    // R11 disable flush
    en_i = 0; step();
    chk("R11 flushed", 16'(level_o), 0);
    push(16'h7777);
    chk("R11 ignored", 16'(level_o), 0);

    // R7 odd bit lock
    odd_wr_i = 1; odd_val_i = 1; step(); odd_wr_i = 0;
    chk("R7 written", 16'(odd_last_o), 1);
    en_i = 1;
    odd_wr_i = 1; odd_val_i = 0; step(); odd_wr_i = 0;
    chk("R7 locked", 16'(odd_last_o), 1);

    // R8 odd final byte
    en_i = 0; step(); en_i = 1;
    size_i = 4'd7; thr_qtr_i = 0; dma_en_i = 1; frame_total_i = 8'd3;
    push(16'h0001);
    chk("R8 not final", 16'(rxne_o), 0);
    push(16'h0002);
    rd(1, d);
    chk("R8 pair", d, 16'h0201);
    push(16'h0003);
    chk("R8 final byte", 16'(rxne_o), 1);
    chk("R8 final dma", 16'(dma_req_o), 1);
    dma_en_i = 0; #1;
    chk("R8 needs dma", 16'(rxne_o), 0);
    dma_en_i = 1;
    rd(0, d);
    chk("R8 data", d, 16'h0003);

    // R11 frame count restarts
    en_i = 0; frame_total_i = 8'd1; step(); en_i = 1;
    push(16'h0004);
    chk("R11 count reset", 16'(rxne_o), 1);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=timeout exp=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule